// File: doc/BRIEF.md
# Raw IR Edge Interval Capture

This block measures the time between edges of a demodulated infrared receiver line so that software can decode any remote-control protocol on its own. A prescaler divides the clock into ticks of a programmable length. An interval counter counts those ticks from one qualifying edge to the next. When a qualifying edge arrives, the block latches the tick count and a flag that tells whether the interval that just ended was a pulse (carrier present) or a space, pulses an interrupt for one cycle, and restarts the count from zero.

Software sets the tick length with a base-time field; the tick is base+1 clocks long. A 1 MHz time base with base = 9 gives 10 µs resolution. Software also chooses which edges qualify, and reads the result either from the discrete capture outputs or from one packed status word. Capture runs only while the enable is set and the mode field selects raw operation. A synchronous clear empties the latched result.

The capture data has no back-pressure. Each result is held until the next qualifying edge replaces it, so software must read it within one edge-to-edge interval.

Top module: `irx_edge_capture`

## Requirements
- R1: After reset with the enable low, `irq`, `cap_interval`, `cap_pulse`, `busy` and `stat_word` are all zero.
- R2: The latched interval equals the number of whole ticks of (`cfg_base`+1) clocks completed since the previous capture. The prescaler restarts at every capture, and a tick that ends in the capture cycle itself is not counted. For edges D clocks apart this gives floor((D-1)/(base+1)).
- R3: `cfg_edge_sel` selects the qualifying edges: 0 = decoder events only (none exist in raw mode, so no capture happens), 1 = rising and falling, 2 = falling only, 3 = rising only.
- R4: `cap_pulse` is 1 when the interval that ended was at line level low (a capture on a rising edge) and 0 when it was high (a capture on a falling edge).
- R5: `ir_in` passes through a two-flop synchronizer. `irq` is high for exactly one cycle, three clock edges after the input changes.
- R6: The interval counter restarts from zero in the cycle the result is latched. `cap_interval` and `cap_pulse` stay unchanged until the next capture or clear.
- R7: The interval counter saturates at 8191 (13 bits) instead of wrapping.
- R8: `busy` is high while capture is running and the counter is below full scale. It is low while capture is disabled and once the counter has saturated.
- R9: A one-cycle `cfg_clr` sets `cap_interval` and `cap_pulse` to zero, restarts the count and raises no interrupt.
- R10: Only mode code 2 (raw) runs capture. Every other code, including 0 (hardware decoding), gives no interrupt and leaves the latched result unchanged.
- R11: While `cfg_en` is low, edges raise no interrupt and the latched result is unchanged.
- R12: `stat_word` carries the interval in bits 28:16, the pulse flag in bit 8 and busy in bit 7. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated IR line, active low, asynchronous |
| cfg_en | input | 1 | Capture enable |
| cfg_clr | input | 1 | Synchronous clear of the capture logic |
| cfg_mode | input | 4 | Operating mode; 2 = raw capture |
| cfg_edge_sel | input | 2 | Qualifying edge selection |
| cfg_base | input | 12 | Tick length minus one, in clocks |
| irq | output | 1 | One-cycle capture interrupt |
| cap_interval | output | 13 | Latched interval in ticks |
| cap_pulse | output | 1 | Latched level flag, 1 = pulse |
| busy | output | 1 | Capture running and counter not saturated |
| stat_word | output | 32 | Packed status word |

## Verification
Two coincidences need care. The first is a prescaler tick that ends in the same cycle as a capture. The bench places edges exactly base+1 and 2·(base+1) clocks apart and requires that the coinciding tick is dropped, as the floor formula in R2 predicts. The second is a capture that arrives while the counter sits at full scale. The bench waits well past 8191 ticks and then requires that the capture reports exactly 8191 and that `busy` had already fallen. A scoreboard holds the expected value for every qualifying edge and compares it with each interrupt.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam logic [3:0] MODE_HWDEC = 4'd0;
  localparam logic [3:0] MODE_RAW   = 4'd2;

  typedef enum logic [1:0] {
    SEL_DECODER = 2'd0,
    SEL_BOTH    = 2'd1,
    SEL_FALL    = 2'd2,
    SEL_RISE    = 2'd3
  } edge_sel_e;

  localparam int IV_LSB    = 16;
  localparam int PULSE_BIT = 8;
  localparam int BUSY_BIT  = 7;
endpackage

// File: rtl/irx_sync_edge.sv
module irx_sync_edge #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic prev,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {CHAIN{IDLE}};
    else        sh_q <= {sh_q[CHAIN-2:0], din};
  end

  assign level = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/irx_prescaler.sv
module irx_prescaler #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] base,
  output logic         tick
);
  logic [W-1:0] pre_q;
  logic         wrap;

  assign wrap = (pre_q >= base);
  assign tick = run & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (!run || restart)  pre_q <= '0;
    else if (wrap)             pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/irx_interval_ctr.sv
module irx_interval_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         cap,
  output logic [W-1:0] cnt,
  output logic         sat
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt_q;

  assign sat = (cnt_q == FULL);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || cap)    cnt_q <= '0;
    else if (tick && !sat)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irx_edge_capture.sv
module irx_edge_capture
  import irx_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int BASE_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              cfg_en,
  input  logic              cfg_clr,
  input  logic [3:0]        cfg_mode,
  input  logic [1:0]        cfg_edge_sel,
  input  logic [BASE_W-1:0] cfg_base,
  output logic              irq,
  output logic [CNT_W-1:0]  cap_interval,
  output logic              cap_pulse,
  output logic              busy,
  output logic [STAT_W-1:0] stat_word
);
  localparam int IV_MSB = IV_LSB + CNT_W - 1;

  logic             run;
  logic             lvl, lvl_prev, rise, fall;
  logic             qual, cap, tick, sat;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] iv_q;
  logic             pulse_q, irq_q;
  edge_sel_e        sel;

  assign run = cfg_en && (cfg_mode == MODE_RAW) && !cfg_clr;
  assign sel = edge_sel_e'(cfg_edge_sel);

  irx_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_in),
    .level(lvl), .prev(lvl_prev), .rise(rise), .fall(fall)
  );

  always_comb begin
    unique case (sel)
      SEL_BOTH: qual = rise | fall;
      SEL_FALL: qual = fall;
      SEL_RISE: qual = rise;
      default:  qual = 1'b0;
    endcase
  end

  assign cap = run & qual;

  irx_prescaler #(.W(BASE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cap),
    .base(cfg_base), .tick(tick)
  );

  irx_interval_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cap(cap),
    .cnt(cnt), .sat(sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q    <= '0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (cfg_clr) begin
      iv_q    <= '0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= cap;
      if (cap) begin
        iv_q    <= cnt;
        pulse_q <= ~lvl_prev;
      end
    end
  end

  assign irq          = irq_q;
  assign cap_interval = iv_q;
  assign cap_pulse    = pulse_q;
  assign busy         = run & ~sat;

  always_comb begin
    stat_word                = '0;
    stat_word[IV_MSB:IV_LSB] = iv_q;
    stat_word[PULSE_BIT]     = pulse_q;
    stat_word[BUSY_BIT]      = busy;
  end
endmodule

// File: rtl/irx_edge_capture_chk.sv
module irx_edge_capture_chk
  import irx_pkg::*;
#(
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_clr,
  input logic [3:0]    cfg_mode,
  input logic          irq,
  input logic          cap_pulse,
  input logic [CW-1:0] cap_interval,
  input logic [CW-1:0] cnt,
  input logic          cap
);
  localparam logic [CW-1:0] FULL = '1;

  // R10 R11
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && cfg_mode == MODE_RAW) |=> !irq);

  // R6
  restart_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0);

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !$past(cfg_clr)) |-> ($stable(cap_interval) && $stable(cap_pulse)));

  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && cfg_en && cfg_mode == MODE_RAW && !cfg_clr && !cap) |=> cnt == FULL);
endmodule

bind irx_edge_capture irx_edge_capture_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_clr(cfg_clr),
  .cfg_mode(cfg_mode), .irq(irq), .cap_pulse(cap_pulse),
  .cap_interval(cap_interval), .cnt(cnt), .cap(cap)
);

// File: tb/sim_irx_edge_capture.sv
`timescale 1ns/1ps
module sim_irx_edge_capture;
  localparam int CW   = 13;
  localparam int FULL = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        cfg_en = 1'b0;
  logic        cfg_clr = 1'b0;
  logic [3:0]  cfg_mode = 4'd0;
  logic [1:0]  cfg_edge_sel = 2'd0;
  logic [11:0] cfg_base = 12'd0;
  logic        irq, cap_pulse, busy;
  logic [12:0] cap_interval;
  logic [31:0] stat_word;

  always #2 clk = ~clk;

  irx_edge_capture u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .cfg_en(cfg_en), .cfg_clr(cfg_clr),
    .cfg_mode(cfg_mode), .cfg_edge_sel(cfg_edge_sel), .cfg_base(cfg_base),
    .irq(irq), .cap_interval(cap_interval), .cap_pulse(cap_pulse),
    .busy(busy), .stat_word(stat_word)
  );

  typedef struct { bit skip; int iv; bit pls; } exp_t;
  exp_t exp_q[$];

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  last_q = 0;
  bit  first_pend = 1'b1;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic bit running();
    return cfg_en && cfg_mode == 4'd2 && !cfg_clr;
  endfunction

  function automatic bit qualifies(input bit v);
    return (cfg_edge_sel == 2'd1) || (cfg_edge_sel == 2'd2 && !v) ||
           (cfg_edge_sel == 2'd3 && v);
  endfunction

  // driver: toggles the line and pushes the expected capture
  task automatic toggle(input int gap);
    bit v;
    exp_t e;
    repeat (gap) @(negedge clk);
    v = ~ir_in;
    ir_in = v;
    if (running() && qualifies(v)) begin
      e.skip = first_pend;
      e.pls  = v;
      e.iv   = (cyc - last_q - 1) / (int'(cfg_base) + 1);
      if (e.iv > FULL) e.iv = FULL;
      exp_q.push_back(e);
      first_pend = 1'b0;
      last_q = cyc;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each interrupt with the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        chk("R3 R10 R11 unexpected interrupt", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4 pulse flag", cap_pulse, e.pls);
        chk("R12 status pulse bit", stat_word[8], e.pls);
        if (!e.skip) begin
          chk("R2 interval", cap_interval, e.iv);
          chk("R12 status interval field", stat_word[28:16], e.iv);
        end
      end
    end
  end

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    int held;
    settle(3);
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 interval after reset", cap_interval, 0);
    chk("R1 status word after reset", stat_word, 0);
    chk("R1 busy after reset", busy, 0);
    rst_n = 1'b1;
    settle(2);

    cfg_base = 12'd3; cfg_mode = 4'd2; cfg_edge_sel = 2'd1; cfg_en = 1'b1;
    first_pend = 1'b1;
    settle(5);
    chk("R8 busy while running", busy, 1);
    chk("R12 status busy bit", stat_word[7], 1);

    // R2 R4 varied gaps, including ticks that coincide with capture
    toggle(6);
    toggle(10); toggle(25); toggle(4); toggle(5); toggle(8); toggle(9); toggle(31);
    settle(6);

    // R5 exact interrupt timing
    toggle(4);
    @(negedge clk); chk("R5 irq one edge after change", irq, 0);
    @(negedge clk); chk("R5 irq two edges after change", irq, 0);
    @(negedge clk); chk("R5 irq three edges after change", irq, 1);
    @(negedge clk); chk("R5 irq is one cycle wide", irq, 0);

    // R6 result stays stable between captures
    held = cap_interval;
    settle(20);
    chk("R6 interval held", cap_interval, held);

    // R3 falling only, then rising only
    cfg_edge_sel = 2'd2; settle(2);
    toggle(7); toggle(12); toggle(6); toggle(14); settle(6);
    cfg_edge_sel = 2'd3; settle(2);
    toggle(9); toggle(11); toggle(5); toggle(13); settle(6);

    // R3 decoder select gives no capture in raw mode
    cfg_edge_sel = 2'd0; settle(2);
    held = cap_interval;
    toggle(5); toggle(5); toggle(5); settle(6);
    chk("R3 decoder select leaves interval", cap_interval, held);
    cfg_edge_sel = 2'd1; settle(2);
    toggle(8); settle(6);

    // R10 non-raw mode
    cfg_mode = 4'd0; first_pend = 1'b1; settle(2);
    chk("R8 busy low in hardware decode mode", busy, 0);
    held = cap_interval;
    toggle(5); toggle(5); settle(6);
    chk("R10 mode 0 leaves interval", cap_interval, held);
    cfg_mode = 4'd2; settle(2);

    // R11 enable low
    cfg_en = 1'b0; first_pend = 1'b1; settle(2);
    chk("R8 busy low when disabled", busy, 0);
    held = cap_interval;
    toggle(5); toggle(5); settle(6);
    chk("R11 disabled leaves interval", cap_interval, held);
    cfg_en = 1'b1; settle(2);

    // R7 saturation
    toggle(4); settle(6);
    settle(33000);
    chk("R8 busy low at full scale", busy, 0);
    toggle(1); settle(6);
    chk("R7 saturated interval", cap_interval, FULL);
    toggle(10); settle(6);

    // R9 clear
    @(negedge clk); cfg_clr = 1'b1;
    @(negedge clk); cfg_clr = 1'b0; first_pend = 1'b1;
    chk("R9 clear zeroes interval", cap_interval, 0);
    chk("R9 clear zeroes pulse", cap_pulse, 0);
    chk("R9 clear zeroes status field", stat_word[28:16], 0);
    settle(3);
    chk("R9 no interrupt from clear", irq, 0);
    toggle(5); toggle(17); settle(8);

    chk("R3 all expected captures seen", exp_q.size(), 0);
    done = 1'b1;
    finish_up();
  end
endmodule